// File: doc/BRIEF.md
# Dual-Output Fixed-Priority Interrupt Router

This block collects twenty-two interrupt sources and sends each one to one of two processor request lines: a normal request or a fast request. Five sources are external pins. They are level-sensitive, and each has its own polarity. They pass through a synchronizer, and a pending bit follows its pin. The other seventeen sources are internal single-cycle pulses. A pulse sets a sticky pending bit, and software clears that bit by writing a one to it.

Software controls the block through a small register port. It sets a per-source enable mask and a per-source steering mask. It reads the raw pending bits, the enabled pending bits, and one result word per output. Each output reports the lowest-numbered source that is enabled, pending and steered to it. When several requests arrive together, the lowest index wins. All outputs are registered.

Top module: `intc_two_out`

## Requirements
- R1: After synchronous reset, the enable mask, the steering mask and all sticky pending bits are zero. `irq_o`, `fiq_o`, both index outputs and `reg_rdata_o` are zero.
- R2: A one-cycle high pulse on `int_pulse_i[j]` sets the pending bit of source 5+j. The bit stays set until software clears it.
- R3: Writing address 0 clears every internal pending bit (index 5..21) whose data bit is 1. A pulse in the same cycle as the clear keeps the bit set.
- R4: Source k (0..4) is pending while `ext_pin_i[k]` is at its active level. Pins 0, 1, 3 and 4 are active low, and pin 2 is active high. Writing ones to bits 0..4 of address 0 has no effect on these bits.
- R5: A source whose enable bit is 0 still shows in the raw pending word (address 0), but it never raises `irq_o` or `fiq_o`.
- R6: Steering bit k equal to 1 sends source k to the fast output. Equal to 0, it sends source k to the normal output.
- R7: `irq_o` (or `fiq_o`) is high exactly one cycle after some source is enabled, pending and steered to that output.
- R8: `irq_idx_o` and `fiq_idx_o` give the lowest-numbered source among those qualifying for that output, with the same one-cycle delay.
- R9: `reg_rdata_o` shows, one cycle after `reg_addr_i` is presented, the register at that address. Address 0 is raw pending, 1 is enable, 2 is steering, and 5 is raw AND enable. Addresses 3 and 4 return the normal and fast result, with bit 31 as the valid flag and bits 4:0 as the index.
- R10: A change on an external pin reaches the pending word after two clock edges and reaches the request output after three.

Top module register map and ports use a 32-bit data word. Bits above 21 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 5 | External level request pins, mixed polarity |
| int_pulse_i | input | 17 | Internal request pulses for sources 5..21 |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal request, registered |
| irq_idx_o | output | 5 | Highest-priority normal source |
| fiq_o | output | 1 | Fast request, registered |
| fiq_idx_o | output | 5 | Highest-priority fast source |

## Verification
An internal pulse or a mask write is seen by the register holding the pending or mask value at the next edge. The request outputs and indices follow one edge after that. An external pin needs two synchronizer edges before its pending bit moves and a third edge before the request output moves. A read returns data one edge after the address is set. The bench changes inputs on falling edges and counts falling edges to the edge at which each result is due. It samples at that falling edge and also checks the cycle just before it where the latency is the subject of the check.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PEND   = 3'd0,
    RA_ENABLE = 3'd1,
    RA_STEER  = 3'd2,
    RA_NORM   = 3'd3,
    RA_FAST   = 3'd4,
    RA_MASKED = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= rst_val;
          else     chain[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= rst_val;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/intc_src_status.sv
module intc_src_status #(
  parameter int               NUM_SRC     = 22,
  parameter int               NUM_EXT     = 5,
  parameter logic [NUM_EXT-1:0] EXT_LOW   = 5'b11011,
  parameter int               SYNC_STAGES = 2,
  localparam int              NUM_INT     = NUM_SRC - NUM_EXT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [NUM_INT-1:0] int_pulse_i,
  input  logic [NUM_SRC-1:0] clr_mask_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_EXT-1:0] pin_sync;
  logic [NUM_INT-1:0] sticky_q;

  // Synchronizer resets to the inactive level of every pin.
  intc_sync #(.W(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (EXT_LOW),
    .d_i     (ext_pin_i),
    .q_o     (pin_sync)
  );

  genvar k;
  generate
    for (k = 0; k < NUM_INT; k++) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst)                          sticky_q[k] <= 1'b0;
        else if (int_pulse_i[k])          sticky_q[k] <= 1'b1;
        else if (clr_mask_i[NUM_EXT + k]) sticky_q[k] <= 1'b0;
      end
    end
  endgenerate

  // Level sources: active when pin differs from its polarity mask bit.
  assign pend_o = {sticky_q, pin_sync ^ EXT_LOW};
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int N     = 22,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_two_out.sv
module intc_two_out
  import intc_pkg::*;
#(
  parameter int                 NUM_SRC     = 22,
  parameter int                 NUM_EXT     = 5,
  parameter logic [NUM_EXT-1:0] EXT_LOW     = 5'b11011,
  parameter int                 SYNC_STAGES = 2,
  localparam int                NUM_INT     = NUM_SRC - NUM_EXT,
  localparam int                IDX_W       = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_EXT-1:0]   ext_pin_i,
  input  logic [NUM_INT-1:0]   int_pulse_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  output logic [IDX_W-1:0]     irq_idx_o,
  output logic                 fiq_o,
  output logic [IDX_W-1:0]     fiq_idx_o
);
  logic [NUM_SRC-1:0] en_q, route_q, status_w, clr_mask;
  logic [NUM_SRC-1:0] req_norm, req_fast;
  logic               norm_any, fast_any;
  logic [IDX_W-1:0]   norm_idx, fast_idx;
  logic [DATA_W-1:0]  rd_next;

  assign clr_mask = (reg_wr_i && reg_addr_i == RA_PEND) ? reg_wdata_i[NUM_SRC-1:0] : '0;

  intc_src_status #(
    .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .EXT_LOW(EXT_LOW), .SYNC_STAGES(SYNC_STAGES)
  ) u_status (
    .clk         (clk),
    .rst         (rst),
    .ext_pin_i   (ext_pin_i),
    .int_pulse_i (int_pulse_i),
    .clr_mask_i  (clr_mask),
    .pend_o      (status_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      route_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == RA_ENABLE) en_q    <= reg_wdata_i[NUM_SRC-1:0];
      if (reg_addr_i == RA_STEER)  route_q <= reg_wdata_i[NUM_SRC-1:0];
    end
  end

  assign req_norm = status_w & en_q & ~route_q;
  assign req_fast = status_w & en_q &  route_q;

  intc_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc_norm (
    .req_i (req_norm), .any_o (norm_any), .idx_o (norm_idx)
  );

  intc_prio_enc #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc_fast (
    .req_i (req_fast), .any_o (fast_any), .idx_o (fast_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      irq_idx_o <= '0;
      fiq_o     <= 1'b0;
      fiq_idx_o <= '0;
    end else begin
      irq_o     <= norm_any;
      irq_idx_o <= norm_idx;
      fiq_o     <= fast_any;
      fiq_idx_o <= fast_idx;
    end
  end

  always_comb begin
    rd_next = '0;
    case (reg_addr_i)
      RA_PEND:   rd_next[NUM_SRC-1:0] = status_w;
      RA_ENABLE: rd_next[NUM_SRC-1:0] = en_q;
      RA_STEER:  rd_next[NUM_SRC-1:0] = route_q;
      RA_NORM:   begin rd_next[DATA_W-1] = irq_o; rd_next[IDX_W-1:0] = irq_idx_o; end
      RA_FAST:   begin rd_next[DATA_W-1] = fiq_o; rd_next[IDX_W-1:0] = fiq_idx_o; end
      RA_MASKED: rd_next[NUM_SRC-1:0] = status_w & en_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_next;
  end
endmodule

// File: rtl/intc_two_out_chk.sv
module intc_two_out_chk #(
  parameter int NUM_SRC = 22,
  parameter int NUM_EXT = 5,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         reg_addr_i,
  input logic               reg_wr_i,
  input logic [31:0]        reg_wdata_i,
  input logic [NUM_SRC-1:0] status_w,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] route_q,
  input logic               irq_o,
  input logic [IDX_W-1:0]   irq_idx_o,
  input logic               fiq_o,
  input logic [IDX_W-1:0]   fiq_idx_o
);
  logic [NUM_SRC-1:0] prev_norm, prev_fast, prev_en, prev_route, prev_stat, prev_clr;
  logic [NUM_SRC-1:0] below_irq, below_fiq, int_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_norm <= '0; prev_fast <= '0; prev_en <= '0;
      prev_route <= '0; prev_stat <= '0; prev_clr <= '0;
    end else begin
      prev_norm  <= status_w & en_q & ~route_q;
      prev_fast  <= status_w & en_q & route_q;
      prev_en    <= en_q;
      prev_route <= route_q;
      prev_stat  <= status_w;
      prev_clr   <= (reg_wr_i && reg_addr_i == 3'd0) ? reg_wdata_i[NUM_SRC-1:0] : '0;
    end
  end

  assign below_irq = (NUM_SRC'(1) << irq_idx_o) - NUM_SRC'(1);
  assign below_fiq = (NUM_SRC'(1) << fiq_idx_o) - NUM_SRC'(1);
  assign int_mask  = ~((NUM_SRC'(1) << NUM_EXT) - NUM_SRC'(1));

  assert_norm_out_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|prev_norm));
  assert_fast_out_R7: assert property (@(posedge clk) disable iff (rst)
    fiq_o == (|prev_fast));
  assert_norm_prio_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((prev_norm & below_irq) == '0));
  assert_fast_prio_R8: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> ((prev_fast & below_fiq) == '0));
  assert_norm_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_idx_o < NUM_SRC && prev_en[irq_idx_o] && prev_stat[irq_idx_o]));
  assert_fast_steer_R6: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> (fiq_idx_o < NUM_SRC && prev_route[fiq_idx_o] && prev_en[fiq_idx_o]));
  assert_norm_steer_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_idx_o < NUM_SRC && !prev_route[irq_idx_o]));
  assert_sticky_clear_R3: assert property (@(posedge clk) disable iff (rst)
    ((prev_stat & ~status_w & int_mask & ~prev_clr) == '0));
endmodule

bind intc_two_out intc_two_out_chk #(
  .NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .status_w    (status_w),
  .en_q        (en_q),
  .route_q     (route_q),
  .irq_o       (irq_o),
  .irq_idx_o   (irq_idx_o),
  .fiq_o       (fiq_o),
  .fiq_idx_o   (fiq_idx_o)
);

// File: tb/intc_two_out_bench.sv
module intc_two_out_bench;
  localparam int NS = 22;
  localparam int NE = 5;
  localparam int NI = NS - NE;
  localparam logic [4:0] LOWMASK = 5'b11011;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  ext_pin = LOWMASK;
  logic [16:0] pulse = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic [4:0]  irq_idx, fiq_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intc_two_out u_intc_two_out (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin), .int_pulse_i(pulse),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .irq_idx_o(irq_idx), .fiq_o(fiq), .fiq_idx_o(fiq_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic fire(input logic [16:0] v);
    @(negedge clk); pulse = v;
    @(negedge clk); pulse = '0;
  endtask

  logic [31:0] rv;

  initial begin
    tick(3);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 fiq", {31'b0, fiq}, 0);
    chk("R1 rdata", rdata, 0);
    @(negedge clk); rst = 1'b0;
    rreg(3'd0, rv); chk("R1 pend", rv, 0);
    rreg(3'd1, rv); chk("R1 enable", rv, 0);
    rreg(3'd2, rv); chk("R1 steer", rv, 0);

    // R9 read-back one cycle after address
    wreg(3'd1, 32'h003F_FFFF);
    rreg(3'd1, rv); chk("R9 enable readback", rv, 32'h003F_FFFF);

    // R2 R3 R6 R7 R8 sweep over internal sources, both steerings
    for (int r = 0; r < 2; r++) begin
      wreg(3'd2, r ? 32'h003F_FFFF : 32'h0);
      for (int j = 0; j < NI; j++) begin
        fire(17'(1) << j);
        tick(1);
        chk(r ? "R6 fast req" : "R7 norm req", {31'b0, r ? fiq : irq}, 1);
        chk("R6 other output idle", {31'b0, r ? irq : fiq}, 0);
        chk("R8 index", {27'b0, r ? fiq_idx : irq_idx}, 32'(NE + j));
        rreg(3'd0, rv); chk("R2 sticky", rv, 32'(1) << (NE + j));
        rreg(r ? 3'd4 : 3'd3, rv); chk("R9 result word", rv, {1'b1, 26'b0, 5'(NE + j)});
        wreg(3'd0, 32'(1) << (NE + j));
        tick(1);
        chk("R3 cleared req", {31'b0, r ? fiq : irq}, 0);
        rreg(3'd0, rv); chk("R3 cleared pend", rv, 0);
      end
    end

    // R8 priority over every pair of internal sources
    wreg(3'd2, 32'h0);
    for (int a = 0; a < NI; a++) begin
      for (int b = a + 1; b < NI; b++) begin
        fire((17'(1) << a) | (17'(1) << b));
        tick(1);
        chk("R8 pair priority", {27'b0, irq_idx}, 32'(NE + a));
        wreg(3'd0, 32'h003F_FFFF);
      end
    end

    // R3 set wins over same-cycle clear
    @(negedge clk); addr = 3'd0; wdata = 32'(1) << 7; wr = 1'b1; pulse = 17'(1) << 2;
    @(negedge clk); wr = 1'b0; pulse = '0;
    rreg(3'd0, rv); chk("R3 set beats clear", rv, 32'(1) << 7);
    wreg(3'd0, 32'(1) << 7);

    // R5 masked source stays visible but silent
    wreg(3'd1, 32'h0);
    fire(17'(1) << 5);
    tick(1);
    chk("R5 masked irq", {31'b0, irq}, 0);
    chk("R5 masked fiq", {31'b0, fiq}, 0);
    rreg(3'd0, rv); chk("R5 raw shows masked", rv, 32'(1) << 10);
    rreg(3'd5, rv); chk("R5 masked word", rv, 0);
    wreg(3'd0, 32'(1) << 10);

    // R4 polarity sweep over every pin pattern, sources disabled
    for (int p = 0; p < 32; p++) begin
      @(negedge clk); ext_pin = 5'(p);
      tick(2);
      rreg(3'd0, rv); chk("R4 pin polarity", rv, {27'b0, 5'(p) ^ LOWMASK});
      chk("R5 disabled pins silent", {31'b0, irq | fiq}, 0);
    end
    @(negedge clk); ext_pin = LOWMASK;
    tick(3);

    // R10 synchronizer latency on pin 0, normal output
    wreg(3'd1, 32'h1F);
    @(negedge clk); ext_pin = LOWMASK & 5'b11110;
    tick(2);
    chk("R10 not yet at edge 2", {31'b0, irq}, 0);
    tick(1);
    chk("R10 request at edge 3", {31'b0, irq}, 1);
    chk("R10 index", {27'b0, irq_idx}, 0);

    // R4 write-one to level bit has no effect
    wreg(3'd0, 32'h1F);
    rreg(3'd0, rv); chk("R4 level ignores clear", rv, 32'h1);

    // R6 steer pin 2 (active high) to fast
    wreg(3'd2, 32'h4);
    @(negedge clk); ext_pin = LOWMASK & 5'b11110 | 5'b00100;
    tick(3);
    chk("R6 pin2 fast", {31'b0, fiq}, 1);
    chk("R6 pin2 fast idx", {27'b0, fiq_idx}, 2);
    chk("R8 pin0 still normal", {26'b0, irq, irq_idx}, 32'h20);

    // R4 deassert releases request
    @(negedge clk); ext_pin = LOWMASK;
    tick(3);
    chk("R4 release", {30'b0, irq, fiq}, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule